// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller made of several identical 8-pin ports. Each port has its own register bank, placed one after another at a fixed stride, behind a simple register bus. The bus has an address, a write strobe, write data and combinational read data. For every pin, the block can:
- drive or release the pad in one of four drive modes;
- enable or disable a pull-up;
- sample the pad;
- latch a single selected edge as a sticky interrupt event.

Each port raises one interrupt line when any of its enabled events is pending. A global control word sits at address zero. It holds a capture enable and an input-synchronizer select, and it reports a version number and the port count as read-only fields. Software keeps the edge selection per pin, and it flips that selection itself when it wants to follow both edges. A force register lets test software inject events without moving the pads.

Top module: `gpio_multiport`

## Requirements
- R1: After reset every register reads 0. Every pad is released (`pad_oe` all 0, `pad_out` all 0), every pull-up is enabled (`pad_pu_en` all 1), and every `irq` bit is 0.
- R2: Port p's bank starts at byte address 0x30*p. It has these registers:
  - data-in at +0x04;
  - data-out at +0x08;
  - pin mode at +0x0C;
  - pull-up disable at +0x10;
  - event at +0x14;
  - interrupt enable at +0x18;
  - force at +0x1C;
  - edge select at +0x20.

  The mode register keeps bits 15:0. The other per-pin registers keep bits 7:0. Unused bits, and any unused offset within a bank (such as +0x00 of a bank other than bank 0), read 0.
- R3: The control word at address 0x00 has these fields:
  - bit 0: capture enable;
  - bit 1: synchronizer select;
  - bits 8:2: the `CORE_VER` parameter;
  - bits 15:9: `NUM_PORTS`.

  Bits 1:0 are writable. Writes to the upper bits have no effect.
- R4: Pin n of a port takes its mode from mode bits [2n+1:2n]:
  - 00 input: the pad is released.
  - 01 push-pull: `pad_oe`=1 and `pad_out` follows the data bit.
  - 10 open-drain: the pad is driven low only when the data bit is 0.
  - 11 open-source: the pad is driven high only when the data bit is 1.

  A released pad shows `pad_out`=0.
- R5: A 1 in pull-up-disable bit n drives `pad_pu_en` for that pin to 0. A 0 drives it to 1.
- R6: With the synchronizer select at 0, data-in bits 7:0 show the port's `pad_in` values in the same cycle.
- R7: Edge-select bit n set to 1 captures a rising edge of the pin into event bit n. Set to 0, it captures a falling edge. The other edge is never captured.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: Writing 1 to a force bit sets the matching event bit. The force register reads 0.
- R10: Port p's `irq[p]` is 1 exactly when some pin of that port has both its event bit and its enable bit set. Other ports' lines are unaffected.
- R11: While capture enable is 0, pad edges set no event bits. Force writes still set them.
- R12: With the synchronizer select at 1, pad inputs pass through two flops before detection and data-in reads. A change appears on data-in after the second clock edge and in the event register after the third. In direct mode, the event is set after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_out | output | 8*NUM_PORTS | Pad drive value |
| pad_oe | output | 8*NUM_PORTS | Pad output enable |
| pad_pu_en | output | 8*NUM_PORTS | Pad pull-up enable |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
The edge-capture assertions assume one thing about pad inputs. In direct mode a pad may change at any time, but its level must settle before the sampling clock edge. The bench meets this by moving pads only at falling clock edges. The event-clear and interrupt-hold properties assume that register writes arrive only as single-cycle strobes with stable address and data. The bench's write task asserts the strobe for one full cycle between two falling edges. Every write uses a word-aligned address, so no access falls between two registers.

// File: rtl/gpio_multiport_pkg.sv
package gpio_multiport_pkg;

  localparam int PORT_PINS   = 8;
  localparam int BANK_STRIDE = 'h30;

  localparam logic [5:0] OFF_DIN  = 6'h04;
  localparam logic [5:0] OFF_DOUT = 6'h08;
  localparam logic [5:0] OFF_MODE = 6'h0C;
  localparam logic [5:0] OFF_PULL = 6'h10;
  localparam logic [5:0] OFF_EVT  = 6'h14;
  localparam logic [5:0] OFF_IEN  = 6'h18;
  localparam logic [5:0] OFF_FRC  = 6'h1C;
  localparam logic [5:0] OFF_EDGE = 6'h20;

  typedef enum logic [1:0] {
    PM_INPUT = 2'b00,
    PM_PUSH  = 2'b01,
    PM_SINK  = 2'b10,
    PM_SRC   = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pad_drv_t;

  // Drive decision for one pin; released pads show val = 0.
  function automatic pad_drv_t pad_drive(pin_mode_e mode, logic d);
    pad_drv_t r;
    unique case (mode)
      PM_PUSH: begin r.oe = 1'b1; r.val = d;    end
      PM_SINK: begin r.oe = ~d;   r.val = 1'b0; end
      PM_SRC:  begin r.oe = d;    r.val = d;    end
      default: begin r.oe = 1'b0; r.val = 1'b0; end
    endcase
    return r;
  endfunction

  // Per-bit edge match: rise_sel=1 wants 0->1, rise_sel=0 wants 1->0.
  function automatic logic [PORT_PINS-1:0] edge_hits(
    logic [PORT_PINS-1:0] prev, logic [PORT_PINS-1:0] cur,
    logic [PORT_PINS-1:0] rise_sel);
    return (rise_sel & ~prev & cur) | (~rise_sel & prev & ~cur);
  endfunction

  // Sticky event update: new sets win over a same-cycle clear.
  function automatic logic [PORT_PINS-1:0] event_next(
    logic [PORT_PINS-1:0] cur, logic [PORT_PINS-1:0] clr,
    logic [PORT_PINS-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [31:0] ctrl_word(logic [6:0] cores,
    logic [6:0] ver, logic [1:0] bits);
    return {16'h0000, cores, ver, bits};
  endfunction

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_sync,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] sampled
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw;
      stage2_q <= stage1_q;
    end
  end

  assign sampled = use_sync ? stage2_q : raw;

  // R12
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_sync && $past(use_sync)) |=> (stage2_q == $past(raw, 2)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_multiport_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int ADDR_W   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [15:0]          bus_wdata,
  input  logic                 capture_en,
  input  logic [PORT_PINS-1:0] smp,
  output logic [31:0]          rd_data,
  output logic [PORT_PINS-1:0] pad_out,
  output logic [PORT_PINS-1:0] pad_oe,
  output logic [PORT_PINS-1:0] pad_pu_en,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(PORT_IDX * BANK_STRIDE);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BANK_STRIDE);

  logic [ADDR_W-1:0] rel;
  logic              in_bank;
  logic [5:0]        off;

  assign rel     = bus_addr - BASE;
  assign in_bank = (bus_addr >= BASE) && (rel < STRIDE);
  assign off     = rel[5:0];

  logic wr_dout, wr_mode, wr_pull, wr_evt, wr_ien, wr_frc, wr_edge;
  assign wr_dout = bus_wr && in_bank && (off == OFF_DOUT);
  assign wr_mode = bus_wr && in_bank && (off == OFF_MODE);
  assign wr_pull = bus_wr && in_bank && (off == OFF_PULL);
  assign wr_evt  = bus_wr && in_bank && (off == OFF_EVT);
  assign wr_ien  = bus_wr && in_bank && (off == OFF_IEN);
  assign wr_frc  = bus_wr && in_bank && (off == OFF_FRC);
  assign wr_edge = bus_wr && in_bank && (off == OFF_EDGE);

  logic [PORT_PINS-1:0]   dout_q, pull_dis_q, ien_q, rise_q, evt_q, prev_q;
  logic [2*PORT_PINS-1:0] mode_q;

  // named internal events for the checks
  logic [PORT_PINS-1:0] hit_raw, hit_gated, frc_set, evt_clr;
  assign hit_raw   = edge_hits(prev_q, smp, rise_q);
  assign hit_gated = capture_en ? hit_raw : '0;
  assign frc_set   = wr_frc ? bus_wdata[PORT_PINS-1:0] : '0;
  assign evt_clr   = wr_evt ? bus_wdata[PORT_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q     <= '0;
      mode_q     <= '0;
      pull_dis_q <= '0;
      ien_q      <= '0;
      rise_q     <= '0;
      evt_q      <= '0;
      prev_q     <= '0;
    end else begin
      if (wr_dout) dout_q     <= bus_wdata[PORT_PINS-1:0];
      if (wr_mode) mode_q     <= bus_wdata[2*PORT_PINS-1:0];
      if (wr_pull) pull_dis_q <= bus_wdata[PORT_PINS-1:0];
      if (wr_ien)  ien_q      <= bus_wdata[PORT_PINS-1:0];
      if (wr_edge) rise_q     <= bus_wdata[PORT_PINS-1:0];
      evt_q  <= event_next(evt_q, evt_clr, hit_gated | frc_set);
      prev_q <= smp;
    end
  end

  for (genvar i = 0; i < PORT_PINS; i++) begin : g_pin
    pad_drv_t drv;
    assign drv          = pad_drive(pin_mode_e'(mode_q[2*i +: 2]), dout_q[i]);
    assign pad_oe[i]    = drv.oe;
    assign pad_out[i]   = drv.val;
    assign pad_pu_en[i] = ~pull_dis_q[i];

    // R7
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(evt_q[i]) && !$past(frc_set[i]) && $past(rise_q[i]))
        |-> ($past(smp[i]) && !$past(prev_q[i])));
    // R7
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(evt_q[i]) && !$past(frc_set[i]) && !$past(rise_q[i]))
        |-> (!$past(smp[i]) && $past(prev_q[i])));
  end

  assign irq = |(evt_q & ien_q);

  always_comb begin
    rd_data = '0;
    if (in_bank) begin
      unique case (off)
        OFF_DIN:  rd_data[PORT_PINS-1:0]   = smp;
        OFF_DOUT: rd_data[PORT_PINS-1:0]   = dout_q;
        OFF_MODE: rd_data[2*PORT_PINS-1:0] = mode_q;
        OFF_PULL: rd_data[PORT_PINS-1:0]   = pull_dis_q;
        OFF_EVT:  rd_data[PORT_PINS-1:0]   = evt_q;
        OFF_IEN:  rd_data[PORT_PINS-1:0]   = ien_q;
        OFF_EDGE: rd_data[PORT_PINS-1:0]   = rise_q;
        default:  rd_data = '0;
      endcase
    end
  end

  // R8
  evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ((evt_q & $past(evt_clr) & ~$past(hit_gated | frc_set)) == '0));
  // R11
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !wr_frc) |=> ((evt_q & ~$past(evt_q)) == '0));
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_evt && !wr_ien) |=> irq);

endmodule

// File: rtl/gpio_multiport.sv
module gpio_multiport
  import gpio_multiport_pkg::*;
#(
  parameter int         NUM_PORTS = 5,
  parameter int         ADDR_W    = 9,
  parameter logic [6:0] CORE_VER  = 7'h0B,
  localparam int        NPINS     = NUM_PORTS * PORT_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu_en,
  output logic [NUM_PORTS-1:0] irq
);
  localparam logic [6:0] CORE_CNT = 7'(NUM_PORTS);

  logic [1:0] ctrl_q;
  logic       ctrl_sel;
  logic       unused_hi;

  assign ctrl_sel  = (bus_addr == '0);
  assign unused_hi = ^bus_wdata[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctrl_q <= '0;
    else if (bus_wr && ctrl_sel) ctrl_q <= bus_wdata[1:0];
  end

  logic [NPINS-1:0] smp_all;

  gpio_insync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_sync (ctrl_q[1]),
    .raw      (pad_in),
    .sampled  (smp_all)
  );

  logic [31:0] port_rd [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port #(.PORT_IDX(p), .ADDR_W(ADDR_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata[15:0]),
      .capture_en (ctrl_q[0]),
      .smp        (smp_all[p*PORT_PINS +: PORT_PINS]),
      .rd_data    (port_rd[p]),
      .pad_out    (pad_out[p*PORT_PINS +: PORT_PINS]),
      .pad_oe     (pad_oe[p*PORT_PINS +: PORT_PINS]),
      .pad_pu_en  (pad_pu_en[p*PORT_PINS +: PORT_PINS]),
      .irq        (irq[p])
    );
  end

  always_comb begin
    bus_rdata = ctrl_sel ? ctrl_word(CORE_CNT, CORE_VER, ctrl_q) : 32'h0;
    for (int p = 0; p < NUM_PORTS; p++) bus_rdata |= port_rd[p];
  end

  // R3
  ctrl_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_sel |-> (bus_rdata[15:2] == {CORE_CNT, CORE_VER}));

endmodule

// File: tb/sim_gpio_multiport.sv
module sim_gpio_multiport;
  localparam int         NP    = 5;
  localparam int         AW    = 9;
  localparam logic [6:0] VER   = 7'h0B;
  localparam int         NPINS = NP * 8;
  localparam logic [31:0] CTRL_ID = (32'(NP) << 9) | (32'(VER) << 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out, pad_oe, pad_pu_en;
  logic [NP-1:0] irq;

  always #5 clk = ~clk;

  gpio_multiport #(.NUM_PORTS(NP), .ADDR_W(AW), .CORE_VER(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // {addr, write data, expected read-back}
  localparam int NT = 9;
  localparam logic [72:0] TBL [NT] = '{
    {9'h000, 32'hFFFF_FFFF, CTRL_ID | 32'h3},
    {9'h008, 32'hFFFF_FFA5, 32'h0000_00A5},
    {9'h00C, 32'hFFFF_1234, 32'h0000_1234},
    {9'h070, 32'h0000_01FF, 32'h0000_00FF},
    {9'h0D8, 32'h0000_005A, 32'h0000_005A},
    {9'h0B0, 32'h0000_03C3, 32'h0000_00C3},
    {9'h04C, 32'h0000_0000, 32'h0000_0000},
    {9'h0C0, 32'h0000_FFFF, 32'h0000_0000},
    {9'h000, 32'h0000_0000, CTRL_ID}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pad_in = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(9'h000, v); chk("R1 ctrl", v, CTRL_ID);
    rd(9'h038, v); chk("R1 dout p1", v, 0);
    rd(9'h0A4, v); chk("R1 evt p3", v, 0);
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 out", 32'(pad_out), 0);
    chk("R1 pu", 32'(&pad_pu_en), 1);
    chk("R1 irq", 32'(irq), 0);

    // R2/R3 table walk
    for (int k = 0; k < NT; k++) begin
      wr(TBL[k][72:64], TBL[k][63:32]);
      rd(TBL[k][72:64], v);
      chk("R2/R3 table", v, TBL[k][31:0]);
    end

    do_reset();

    // R4 modes on port 0: pin0 push, pin1 sink, pin2 source, pin3 input
    wr(9'h00C, 32'h0000_0039);
    wr(9'h008, 32'h0000_0000);
    chk("R4 oe d=0", 32'(pad_oe[3:0]), 32'h3);
    chk("R4 out d=0", 32'(pad_out[3:0]), 32'h0);
    wr(9'h008, 32'h0000_000F);
    chk("R4 oe d=1", 32'(pad_oe[3:0]), 32'h5);
    chk("R4 out d=1", 32'(pad_out[3:0]), 32'h5);

    // R5 pull-up disable on port 2
    wr(9'h070, 32'h0000_000F);
    chk("R5 pu", 32'(pad_pu_en[23:16]), 32'hF0);

    // R6 direct input read on port 1
    @(negedge clk); pad_in[15:8] = 8'hA6;
    rd(9'h034, v); chk("R6 din", v, 32'hA6);
    @(negedge clk); pad_in[15:8] = 8'h00;
    do_reset();

    // R7 edges on port 1: pin8 rising, others falling
    wr(9'h000, 32'h1);
    wr(9'h050, 32'h01);
    @(negedge clk); pad_in[9:8] = 2'b11;
    @(negedge clk); rd(9'h044, v); chk("R7 rise only", v, 32'h01);
    pad_in[9] = 1'b0;
    @(negedge clk); rd(9'h044, v); chk("R7 fall", v, 32'h03);

    // R8 write-one-to-clear
    wr(9'h044, 32'h00); rd(9'h044, v); chk("R8 zero keeps", v, 32'h03);
    wr(9'h044, 32'h01); rd(9'h044, v); chk("R8 one clears", v, 32'h02);

    // R10 interrupt line
    chk("R10 no enable", 32'(irq), 0);
    wr(9'h048, 32'h02);
    chk("R10 raised", 32'(irq), 32'h02);
    wr(9'h044, 32'h02);
    chk("R10 cleared", 32'(irq), 0);

    // R9 force
    wr(9'h04C, 32'h80); rd(9'h044, v); chk("R9 force sets", v, 32'h80);
    rd(9'h04C, v); chk("R9 force reads 0", v, 0);
    wr(9'h044, 32'h80);

    // R11 capture disabled
    wr(9'h000, 32'h0);
    @(negedge clk); pad_in[10] = 1'b1;
    @(negedge clk); pad_in[10] = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(9'h044, v); chk("R11 no capture", v, 0);
    wr(9'h04C, 32'h04); rd(9'h044, v); chk("R11 force works", v, 32'h04);
    wr(9'h044, 32'h04);

    // R12 synchronizer: pin8 rising again
    wr(9'h000, 32'h3);
    @(negedge clk); pad_in[8] = 1'b0;
    repeat (4) @(negedge clk);
    wr(9'h044, 32'hFF);
    pad_in[8] = 1'b1;
    @(negedge clk);
    rd(9'h044, v); chk("R12 evt e1", v, 0);
    rd(9'h034, v); chk("R12 din e1", v, 0);
    @(negedge clk);
    rd(9'h044, v); chk("R12 evt e2", v, 0);
    rd(9'h034, v); chk("R12 din e2", v, 32'h01);
    @(negedge clk);
    rd(9'h044, v); chk("R12 evt e3", v, 32'h01);

    // R12 direct mode contrast
    wr(9'h000, 32'h1);
    @(negedge clk); pad_in[8] = 1'b0;
    repeat (2) @(negedge clk);
    wr(9'h044, 32'hFF);
    pad_in[8] = 1'b1;
    @(negedge clk);
    rd(9'h044, v); chk("R12 direct e1", v, 32'h01);

    done = 1;
    finish_run();
  end
endmodule